// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target Engine

This block makes a 256-byte on-chip memory answer on a two-wire I2C bus the way a small serial EEPROM does. The SCL and SDA lines are sampled with a fast system clock. The block finds Start and Stop conditions and decodes the first byte of every transfer as a control byte. It acknowledges a matching control byte by pulling SDA low, and SDA is only ever driven through a pull-low enable.

A write transfer loads a shared address pointer from its first byte. The data bytes that follow go into a page buffer, and a Stop commits the buffered bytes to the array. While that commit runs, including a programmable hold time, the block answers nothing, so a bus master can poll for completion. A read transfer streams bytes starting at the pointer and advances the pointer after each byte. The same pointer carries over between transfers, which makes current-address reads, random reads and sequential reads possible.

Top module: `eeprom_i2c_target`

## Requirements
- R1: After reset the SDA pull-low output `sda_pull_o` is 0.
- R2: The control byte is the first byte after a Start. Bits 7..4 must be 1010, bits 3..1 must equal `sel_i[2:0]` and bit 0 selects read (1) or write (0). A mismatch gets no acknowledge, and the block ignores the bus until the next Start, even if a matching byte follows without a Start.
- R3: An acknowledge holds SDA low for the whole SCL-high part of the ninth clock. `sda_pull_o` changes only while the synchronized SCL is low.
- R4: While an internal write is running, even a matching control byte gets no acknowledge. Acknowledges return once the write has finished.
- R5: In a write transfer, the byte after the control byte loads the pointer. Each later byte is acknowledged and buffered, and a Stop starts an internal write of the buffered bytes lasting about `HOLD_CYCLES` clocks.
- R6: During a write, only the low log2(`PAGE_BYTES`) pointer bits advance, wrapping inside the page. Bytes beyond a page length overwrite the earliest ones in the buffer.
- R7: A random read works as follows: a write control byte, an address byte, a repeated Start and a read control byte. It returns the byte at that address and writes nothing.
- R8: A current-address read returns the byte at the pointer, which is one past the last byte written or read.
- R9: A master acknowledge after a read byte yields the next byte. The pointer rolls from 0xFF to 0x00.
- R10: After a master non-acknowledge on a read byte, SDA stays released until the next Start or Stop.
- R11: A repeated Start aborts a transfer. Data bytes buffered before it are discarded, and control-byte reception restarts at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it |
| sel_i | input | 3 | Strap value compared with control-byte bits 3..1 |

## Verification
The bench builds the block with 8-bit addressing, 16-byte pages and a hold time of 300 clocks. With that short hold time, polling during a write and completion of the write both fall within a single short run. The small strap space allows a full sweep of all 8 strap settings against all 8 select codes, and a sweep of every wrong device code. The 256-entry array is small enough to keep a full model in the bench, so page wrap, buffer overrun and the pointer rollover at 0xFF can each be compared byte by byte.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK, ST_SKIP
  } eng_st_t;

  typedef enum logic [1:0] {
    K_CTRL, K_ADDR, K_DATA
  } rx_kind_t;
endpackage

// File: rtl/line_sampler.sv
module line_sampler (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_m, sda_m, scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_m <= 1'b1; sda_m <= 1'b1;
      scl_s <= 1'b1; sda_s <= 1'b1;
      scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_m <= scl_i; sda_m <= sda_i;
      scl_s <= scl_m; sda_s <= sda_m;
      scl_q <= scl_s; sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/byte_store.sv
module byte_store #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [7:0]        wd,
  input  logic [ADDR_W-1:0] ra,
  output logic [7:0]        rd
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd <= mem[ra];
  end
endmodule

// File: rtl/page_writer.sv
module page_writer #(
  parameter int ADDR_W      = 8,
  parameter int PAGE_BYTES  = 16,
  parameter int HOLD_CYCLES = 2000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              commit,
  input  logic              abort,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wd
);
  localparam int PG_W = $clog2(PAGE_BYTES);
  localparam int HC_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [PG_W-1:0] LAST_IDX = PG_W'(PAGE_BYTES - 1);
  localparam logic [HC_W-1:0] LAST_CNT = HC_W'(HOLD_CYCLES - 1);

  logic [7:0]             pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0]  vld;
  logic [ADDR_W-PG_W-1:0] base;
  logic                   drain;
  logic [PG_W-1:0]        idx;
  logic [HC_W-1:0]        cnt;

  always_ff @(posedge clk) begin
    if (wr_en) pbuf[wr_addr[PG_W-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0; base <= '0; drain <= 1'b0; idx <= '0; cnt <= '0;
      busy <= 1'b0; mem_we <= 1'b0; mem_addr <= '0; mem_wd <= '0;
    end else begin
      mem_we <= 1'b0;
      if (abort && !busy) vld <= '0;
      if (wr_en) begin
        vld[wr_addr[PG_W-1:0]] <= 1'b1;
        base <= wr_addr[ADDR_W-1:PG_W];
      end
      if (commit) begin
        busy <= 1'b1; drain <= 1'b1; idx <= '0; cnt <= '0;
      end else if (drain) begin
        if (vld[idx]) begin
          mem_we   <= 1'b1;
          mem_addr <= {base, idx};
          mem_wd   <= pbuf[idx];
          vld[idx] <= 1'b0;
        end
        idx <= idx + 1'b1;
        if (idx == LAST_IDX) drain <= 1'b0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (cnt == LAST_CNT) busy <= 1'b0;
      end
    end
  end

  // R4: the engine never forwards a data byte while a write is running
  a_r4_no_fill_busy: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && busy));
  // R5: a commit always starts an internal write
  a_r5_commit_busy: assert property (@(posedge clk) disable iff (rst)
    commit |=> busy);
endmodule

// File: rtl/proto_engine.sv
module proto_engine
  import eeprom_i2c_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int PAGE_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [2:0]        sel_i,
  input  logic              busy_i,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] ptr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              commit,
  output logic              abort,
  output logic              sda_pull_o
);
  localparam int PG_W = $clog2(PAGE_BYTES);
  localparam logic [PG_W-1:0] PG_ONE = PG_W'(1);

  eng_st_t  st;
  rx_kind_t kind;
  logic [3:0] cnt;
  logic [7:0] shreg;
  logic       rd_mode, pend, mack;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; kind <= K_CTRL; cnt <= '0; shreg <= '0;
      rd_mode <= 1'b0; pend <= 1'b0; mack <= 1'b0; ptr <= '0;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
      commit <= 1'b0; abort <= 1'b0; sda_pull_o <= 1'b0;
    end else begin
      wr_en <= 1'b0; commit <= 1'b0; abort <= 1'b0;
      if (start_ev) begin
        st <= ST_RX; kind <= K_CTRL; cnt <= '0;
        sda_pull_o <= 1'b0;
        abort <= pend; pend <= 1'b0;
      end else if (stop_ev) begin
        st <= ST_IDLE; sda_pull_o <= 1'b0;
        commit <= pend; pend <= 1'b0;
      end else begin
        unique case (st)
          ST_RX: begin
            if (scl_rise && cnt != 4'd8) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 1'b1;
            end
            if (scl_fall && cnt == 4'd8) begin
              unique case (kind)
                K_CTRL: begin
                  if (shreg[7:4] == DEV_CODE && shreg[3:1] == sel_i && !busy_i) begin
                    sda_pull_o <= 1'b1; rd_mode <= shreg[0]; st <= ST_ACK;
                  end else begin
                    st <= ST_SKIP;
                  end
                end
                K_ADDR: begin
                  ptr <= shreg; sda_pull_o <= 1'b1; st <= ST_ACK;
                end
                default: begin
                  wr_en <= 1'b1; wr_addr <= ptr; wr_data <= shreg;
                  ptr <= {ptr[ADDR_W-1:PG_W], ptr[PG_W-1:0] + PG_ONE};
                  pend <= 1'b1; sda_pull_o <= 1'b1; st <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (rd_mode) begin
                shreg <= rd_data; sda_pull_o <= ~rd_data[7];
                cnt <= 4'd1; st <= ST_TX;
              end else begin
                sda_pull_o <= 1'b0; cnt <= '0; st <= ST_RX;
                kind <= (kind == K_CTRL) ? K_ADDR : K_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_pull_o <= 1'b0; st <= ST_MACK; ptr <= ptr + 1'b1;
              end else begin
                shreg <= {shreg[6:0], 1'b0};
                sda_pull_o <= ~shreg[6];
                cnt <= cnt + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) mack <= ~sda_s;
            if (scl_fall) begin
              if (mack) begin
                shreg <= rd_data; sda_pull_o <= ~rd_data[7];
                cnt <= 4'd1; st <= ST_TX;
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R3: the SDA enable only ever moves while SCL is low
  a_r3_move_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull_o) |-> !scl_s);
  // R4: a control-byte acknowledge is never given while busy
  a_r4_no_ack_busy: assert property (@(posedge clk) disable iff (rst)
    ($rose(sda_pull_o) && $past(st == ST_RX && kind == K_CTRL)) |-> !$past(busy_i));
  // R10: after a master non-acknowledge the line stays released
  a_r10_release: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SKIP) |-> !sda_pull_o);
endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target #(
  parameter int ADDR_W      = 8,
  parameter int PAGE_BYTES  = 16,
  parameter int HOLD_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic [2:0] sel_i
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic [ADDR_W-1:0] ptr, wr_addr, mem_addr;
  logic [7:0] wr_data, mem_wd, rd_data;
  logic wr_en, commit, abort, busy, mem_we;

  line_sampler u_smp (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  proto_engine #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_eng (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .sel_i(sel_i), .busy_i(busy), .rd_data(rd_data), .ptr(ptr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit(commit), .abort(abort), .sda_pull_o(sda_pull_o)
  );

  page_writer #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .HOLD_CYCLES(HOLD_CYCLES)) u_pw (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit(commit), .abort(abort), .busy(busy),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wd(mem_wd)
  );

  byte_store #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we(mem_we), .wa(mem_addr), .wd(mem_wd), .ra(ptr), .rd(rd_data)
  );
endmodule

// File: tb/sim_eeprom_i2c_target.sv
module sim_eeprom_i2c_target;
  localparam int HOLD = 300;
  localparam int PAGE = 16;
  localparam int Q    = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [2:0] sel = 3'd0;
  logic pull;
  logic sda_bus;
  int n_chk = 0, n_err = 0;
  logic [7:0] model [256];

  always #2.5 clk = ~clk;
  assign sda_bus = m_sda & ~pull;

  eeprom_i2c_target #(.ADDR_W(8), .PAGE_BYTES(PAGE), .HOLD_CYCLES(HOLD)) u0 (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_pull_o(pull), .sel_i(sel)
  );

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(Q);
  endtask

  task automatic clk_bit(input logic b, output logic s1, output logic s2);
    m_sda = b; wq(Q); m_scl = 1'b1; wq(Q); s1 = sda_bus; wq(Q - 1); s2 = sda_bus;
    wq(1); m_scl = 1'b0; wq(Q);
  endtask

  task automatic send(input logic [7:0] b, output logic ack, output logic stab);
    logic s1, s2;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s1, s2);
    clk_bit(1'b1, s1, s2);
    ack = ~s1; stab = (s1 == s2);
  endtask

  task automatic recv(input logic give_ack, output logic [7:0] d);
    logic s1, s2;
    d = '0;
    for (int i = 0; i < 8; i++) begin clk_bit(1'b1, s1, s2); d = {d[6:0], s1}; end
    clk_bit(~give_ack, s1, s2);
  endtask

  function automatic logic [7:0] ctl(input logic [2:0] s, input logic rw);
    return {4'b1010, s, rw};
  endfunction

  task automatic wr_page(input logic [7:0] a, input int n, input string tag);
    logic ack, stab;
    bus_start();
    send(ctl(sel, 1'b0), ack, stab); chk({tag, " ctrl ack"}, ack, 1);
    send(a, ack, stab); chk({tag, " addr ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = 8'(a * 7 + i * 13 + 5);
      send(d, ack, stab); chk({tag, " data ack"}, ack, 1);
      model[{a[7:4], 4'(a[3:0] + i)}] = d;
    end
    bus_stop();
  endtask

  task automatic rd_seq(input logic [7:0] a, input int n, input string tag);
    logic ack, stab;
    logic [7:0] d;
    bus_start();
    send(ctl(sel, 1'b0), ack, stab); chk({tag, " ctrl ack"}, ack, 1);
    send(a, ack, stab); chk({tag, " addr ack"}, ack, 1);
    bus_start();
    send(ctl(sel, 1'b1), ack, stab); chk({tag, " read ctrl ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      recv(i != n - 1, d);
      chk(tag, d, model[8'(a + i)]);
    end
    bus_stop();
  endtask

  task automatic cur_read(input logic [7:0] exp_a, input string tag);
    logic ack, stab;
    logic [7:0] d;
    bus_start();
    send(ctl(sel, 1'b1), ack, stab); chk({tag, " ctrl ack"}, ack, 1);
    recv(1'b0, d);
    chk(tag, d, model[exp_a]);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic ack, stab, s1, s2;
    logic [7:0] d;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    wq(5); rst = 1'b0; wq(3);
    chk("R1 reset pull", pull, 0);

    // R2 / R3: every strap value against every select code
    for (int s = 0; s < 8; s++) begin
      sel = 3'(s);
      for (int c = 0; c < 8; c++) begin
        bus_start();
        send(ctl(3'(c), 1'b0), ack, stab);
        chk("R2 select match", ack, (c == s) ? 1 : 0);
        if (c == s) chk("R3 ack stable through high", stab, 1);
        bus_stop();
      end
    end
    // R2: every wrong device code, and no recovery without Start
    sel = 3'd3;
    for (int code = 0; code < 16; code++) begin
      if (code == 10) continue;
      bus_start();
      send({4'(code), sel, 1'b0}, ack, stab);
      chk("R2 wrong code", ack, 0);
      send(ctl(sel, 1'b0), ack, stab);
      chk("R2 ignored until Start", ack, 0);
      bus_stop();
    end

    // R5 / R4: page write then acknowledge polling
    sel = 3'd5;
    wr_page(8'h30, 16, "R5 page write");
    bus_start();
    send(ctl(sel, 1'b0), ack, stab); chk("R4 no ack while busy", ack, 0);
    bus_stop();
    wq(HOLD + PAGE + 40);
    bus_start();
    send(ctl(sel, 1'b0), ack, stab); chk("R4 ack after write", ack, 1);
    bus_stop();

    // R7 random read, R8 current-address reads
    rd_seq(8'h35, 1, "R7 random read");
    cur_read(8'h36, "R8 current read");
    cur_read(8'h37, "R8 current read next");
    // R9 sequential read of the whole page
    rd_seq(8'h30, 16, "R9 sequential");

    // R9 rollover at the top of the array
    wr_page(8'hF8, 8, "R9 top write");
    wq(HOLD + PAGE + 40);
    wr_page(8'h00, 4, "R9 bottom write");
    wq(HOLD + PAGE + 40);
    rd_seq(8'hFD, 6, "R9 rollover");

    // R6 page wrap and overrun
    wr_page(8'h5C, 6, "R6 wrap write");
    wq(HOLD + PAGE + 40);
    rd_seq(8'h50, 16, "R6 wrap");
    wr_page(8'h60, 18, "R6 overrun write");
    wq(HOLD + PAGE + 40);
    rd_seq(8'h60, 16, "R6 overrun");
    cur_read(8'h70, "R8 pointer after read");

    // R11: data then repeated Start is discarded
    bus_start();
    send(ctl(sel, 1'b0), ack, stab); chk("R11 ctrl ack", ack, 1);
    send(8'h80, ack, stab); chk("R11 addr ack", ack, 1);
    send(8'hAA, ack, stab); chk("R11 data ack", ack, 1);
    bus_start();
    send(ctl(sel, 1'b1), ack, stab); chk("R11 immediate ack", ack, 1);
    recv(1'b0, d);
    chk("R11 pointer advanced", d, model[8'h81]);
    // R10: line stays released after master non-acknowledge
    clk_bit(1'b1, s1, s2);
    chk("R10 released", {s1, s2}, 2'b11);
    chk("R10 pull off", pull, 0);
    bus_stop();
    wq(HOLD + PAGE + 40);
    rd_seq(8'h80, 1, "R11 nothing written");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule